// File: doc/BRIEF.md
# Short Vector Lock Mask Generator

This block sits in the decode stage of a floating-point coprocessor pipeline. From a decoded operation descriptor it works out which of the 32 single-precision register slots the operation reads and which it writes. It turns those into two 32-bit lock masks, one for sources and one for destinations, that the scoreboard in the following stage checks and sets. A short-vector operation touches one register set per iteration, and the masks cover every iteration. The two masks appear on the outputs one clock after the descriptor is presented.

Which source registers are locked depends on the compliance mode. In full-compliance mode an operation may be handed off to support code, so every source register of every iteration stays locked. The destination of a multiply-accumulate counts as a source as well. In the fast mode no hand-off can happen, so only the later iterations of long vectors keep their sources locked. The cut-off is one iteration index for single precision and a lower one for double precision. Stores are handled separately. A lone store locks its data register only in full-compliance mode. A store of several registers locks a linear run of registers in both modes.

Top module: `vec_lock_mask_gen`

## Requirements
- R1: `out_valid` equals the `in_valid` value sampled at the previous rising clock edge. The masks shown with it belong to the descriptor captured at that edge.
- R2: While `rst_n` is low at a clock edge, and in any cycle with `out_valid` low, both `src_mask` and `dst_mask` are all zeros.
- R3: Register index encoding is as follows. For single precision, the index is the slot number 0..31. Iteration i of an arithmetic operation uses slot `{idx[4:3], (idx[2:0]+i) mod 8}`, wrapping inside its 8-slot bank, and slot n sets mask bit n.
- R4: For double precision, `idx[3:0]` is the double register d and `idx[4]` is ignored. Iteration i of an arithmetic operation uses double `{d[3:2], (d[1:0]+i) mod 4}`. Double register e sets mask bits 2e and 2e+1.
- R5: `len_m1` holds the vector length minus one (0..7 means 1..8 iterations). An arithmetic operation with `is_scalar` high or `len_m1` of 0 has exactly one iteration. For any arithmetic operation, `dst_mask` is the union of the destination registers of all its iterations.
- R6: In full-compliance mode (`runfast` low), the source mask of an arithmetic operation is the union of both source operands (`src_a_idx`, `src_b_idx`) over all iterations.
- R7: With `is_mac` high, the destination registers of every source-locked iteration are also added to `src_mask`.
- R8: In fast mode (`runfast` high), single precision, only iterations with index i >= 4 (the fifth onward) contribute to `src_mask`. A scalar operation, or a vector of length 4 or less, gives an empty source mask.
- R9: In fast mode, double precision, only iterations with index i >= 2 (the third onward) contribute to `src_mask`.
- R10: `is_store` high with `is_multi` low is a single store. Its source is the register at `src_a_idx` in full-compliance mode, and nothing in fast mode. `dst_mask` is zero.
- R11: `is_store` high with `is_multi` high is a multiple store. It locks `len_m1+1` consecutive registers starting at `src_a_idx`, wrapping modulo 32 slots for single precision and modulo 16 doubles for double precision. It locks them in both modes, ignores `is_scalar`, and leaves `dst_mask` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Descriptor present this cycle |
| src_a_idx | input | 5 | First source base index (store data base for stores) |
| src_b_idx | input | 5 | Second source base index |
| dst_idx | input | 5 | Destination base index |
| len_m1 | input | 3 | Vector length minus one |
| is_double | input | 1 | Double precision operation |
| is_mac | input | 1 | Multiply-accumulate, destination also read |
| is_scalar | input | 1 | Force a single iteration for arithmetic operations |
| is_store | input | 1 | Operation is a store |
| is_multi | input | 1 | Store covers several registers |
| runfast | input | 1 | Fast mode; low selects full-compliance mode |
| out_valid | output | 1 | Masks valid |
| src_mask | output | 32 | Source lock mask, bit n for slot n |
| dst_mask | output | 32 | Destination lock mask, bit n for slot n |

## Verification
Every result is due exactly one rising edge after its descriptor is driven, because a single output register sits between inputs and outputs. The driver changes inputs on falling edges and queues the expected masks at that moment. The monitor samples one fraction of a period after each rising edge. At that point it compares `out_valid` with the `in_valid` seen on that edge and pops exactly one expected entry per valid output. Idle cycles are mixed into the stream, so a result that arrives one cycle early or late misaligns the queue and is reported.

// File: rtl/vlm_pkg.sv
// Package: shared sizes and operation classes for the lock mask generator.
// Assumes a register file of single-precision slots grouped in equal banks,
// with a double register taking two adjacent slots.
package vlm_pkg;
    localparam int VLM_NREG    = 32;  // single-precision slots
    localparam int VLM_BANK    = 8;   // slots per vector bank
    localparam int VLM_MAXLEN  = 8;   // longest vector
    localparam int VLM_RF_SP   = 4;   // first source-locked iteration, fast mode, single
    localparam int VLM_RF_DP   = 2;   // first source-locked iteration, fast mode, double

    typedef enum logic [1:0] {
        OPK_ARITH       = 2'd0,
        OPK_STORE_ONE   = 2'd1,
        OPK_STORE_MULTI = 2'd2
    } op_kind_e;

    // Classify a descriptor from its store flags.
    function automatic op_kind_e vlm_classify(input logic st, input logic multi);
        if (!st)        return OPK_ARITH;
        else if (multi) return OPK_STORE_MULTI;
        else            return OPK_STORE_ONE;
    endfunction
endpackage

// File: rtl/vlm_iter_map.sv
// Module: vlm_iter_map
// Maps one base register index to a per-iteration slot mask for every
// possible iteration. Banked mode wraps inside the base's bank; linear mode
// wraps across the whole file. Double precision doubles the stride and sets
// two adjacent bits. Assumes NREG and BANK are powers of two, BANK < NREG.
module vlm_iter_map #(
    parameter int NREG   = vlm_pkg::VLM_NREG,
    parameter int BANK   = vlm_pkg::VLM_BANK,
    parameter int MAXLEN = vlm_pkg::VLM_MAXLEN
) (
    input  logic [$clog2(NREG)-1:0]       base,
    input  logic                          is_double,
    input  logic                          linear,
    output logic [MAXLEN-1:0][NREG-1:0]   iter_mask
);
    localparam int RW = $clog2(NREG);
    localparam int BW = $clog2(BANK);

    logic [RW-1:0] base_s;

    // Convert the base to slot units (double index shifted up by one).
    always_comb begin
        base_s = is_double ? {base[RW-2:0], 1'b0} : base;
    end

    for (genvar it = 0; it < MAXLEN; it++) begin : g_iter
        localparam logic [RW:0] STEP = (RW+1)'(it);
        logic [RW:0]   sum;
        logic [RW-1:0] pos;
        logic [RW-1:0] pos_hi;

        // Slot of this iteration and its mask bit(s).
        always_comb begin
            sum    = {1'b0, base_s} + (is_double ? (STEP << 1) : STEP);
            if (linear) pos = sum[RW-1:0];
            else        pos = {base_s[RW-1:BW], sum[BW-1:0]};
            pos_hi = pos | RW'(1);
            iter_mask[it] = (NREG'(1) << pos)
                          | (is_double ? (NREG'(1) << pos_hi) : '0);
        end
    end
endmodule

// File: rtl/vlm_iter_gate.sv
// Module: vlm_iter_gate
// Decides, per iteration, whether it exists and which of its operands are
// locked: the destination set, the two source operands and the accumulator.
// Assumes len_m1 is the vector length minus one.
module vlm_iter_gate #(
    parameter int MAXLEN = vlm_pkg::VLM_MAXLEN,
    parameter int RF_SP  = vlm_pkg::VLM_RF_SP,
    parameter int RF_DP  = vlm_pkg::VLM_RF_DP
) (
    input  logic [$clog2(MAXLEN)-1:0] len_m1,
    input  vlm_pkg::op_kind_e         kind,
    input  logic                      is_double,
    input  logic                      is_mac,
    input  logic                      is_scalar,
    input  logic                      runfast,
    output logic [MAXLEN-1:0]         en_dst,
    output logic [MAXLEN-1:0]         en_src_a,
    output logic [MAXLEN-1:0]         en_src_b,
    output logic [MAXLEN-1:0]         en_src_d
);
    import vlm_pkg::*;
    localparam int LW = $clog2(MAXLEN);

    logic [LW-1:0] eff_m1;
    logic          arith;

    // Effective iteration count: one for single stores and scalar arithmetic.
    always_comb begin
        arith = (kind == OPK_ARITH);
        case (kind)
            OPK_STORE_ONE:   eff_m1 = '0;
            OPK_STORE_MULTI: eff_m1 = len_m1;
            default:         eff_m1 = is_scalar ? '0 : len_m1;
        endcase
    end

    for (genvar it = 0; it < MAXLEN; it++) begin : g_iter
        localparam int FIRST_SP = RF_SP;
        localparam int FIRST_DP = RF_DP;
        logic active;
        logic keep;

        // Per-iteration enables, applying the fast-mode thresholds.
        always_comb begin
            active = (LW'(it) <= eff_m1);
            keep   = !runfast || (is_double ? (it >= FIRST_DP) : (it >= FIRST_SP));
            case (kind)
                OPK_STORE_ONE:   en_src_a[it] = active && !runfast;
                OPK_STORE_MULTI: en_src_a[it] = active;
                default:         en_src_a[it] = active && keep;
            endcase
            en_src_b[it] = arith && active && keep;
            en_src_d[it] = arith && is_mac && active && keep;
            en_dst[it]   = arith && active;
        end
    end
endmodule

// File: rtl/vlm_mask_fold.sv
// Module: vlm_mask_fold
// ORs together the slot masks of the enabled iterations.
module vlm_mask_fold #(
    parameter int NREG   = vlm_pkg::VLM_NREG,
    parameter int MAXLEN = vlm_pkg::VLM_MAXLEN
) (
    input  logic [MAXLEN-1:0][NREG-1:0] iter_mask,
    input  logic [MAXLEN-1:0]           en,
    output logic [NREG-1:0]             mask
);
    // Union of the selected iteration masks.
    always_comb begin
        mask = '0;
        for (int it = 0; it < MAXLEN; it++) begin
            if (en[it]) mask = mask | iter_mask[it];
        end
    end
endmodule

// File: rtl/vec_lock_mask_gen.sv
// Module: vec_lock_mask_gen
// Decode-stage generator of source and destination lock masks for scalar and
// short-vector operations. Maps the three base indices per iteration, gates
// iterations by length, mode and precision, folds them into two masks and
// registers the result. Synchronous active-low reset. Assumes the descriptor
// is already decoded into the fields on the port list.
module vec_lock_mask_gen #(
    parameter int NREG   = vlm_pkg::VLM_NREG,
    parameter int BANK   = vlm_pkg::VLM_BANK,
    parameter int MAXLEN = vlm_pkg::VLM_MAXLEN,
    parameter int RF_SP  = vlm_pkg::VLM_RF_SP,
    parameter int RF_DP  = vlm_pkg::VLM_RF_DP
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [$clog2(NREG)-1:0]     src_a_idx,
    input  logic [$clog2(NREG)-1:0]     src_b_idx,
    input  logic [$clog2(NREG)-1:0]     dst_idx,
    input  logic [$clog2(MAXLEN)-1:0]   len_m1,
    input  logic                        is_double,
    input  logic                        is_mac,
    input  logic                        is_scalar,
    input  logic                        is_store,
    input  logic                        is_multi,
    input  logic                        runfast,
    output logic                        out_valid,
    output logic [NREG-1:0]             src_mask,
    output logic [NREG-1:0]             dst_mask
);
    import vlm_pkg::*;
    localparam int LW = $clog2(MAXLEN);

    op_kind_e                    kind;
    logic                        a_linear;
    logic [MAXLEN-1:0][NREG-1:0] map_a, map_b, map_d;
    logic [MAXLEN-1:0]           en_dst, en_a, en_b, en_d;
    logic [NREG-1:0]             fold_a, fold_b, fold_d_src, fold_dst;
    logic [NREG-1:0]             src_next;

    // Classify the descriptor; only multiple stores walk linearly.
    always_comb begin
        kind     = vlm_classify(is_store, is_multi);
        a_linear = (kind == OPK_STORE_MULTI);
    end

    vlm_iter_map #(.NREG(NREG), .BANK(BANK), .MAXLEN(MAXLEN)) u_map_a (
        .base(src_a_idx), .is_double(is_double), .linear(a_linear), .iter_mask(map_a));
    vlm_iter_map #(.NREG(NREG), .BANK(BANK), .MAXLEN(MAXLEN)) u_map_b (
        .base(src_b_idx), .is_double(is_double), .linear(1'b0), .iter_mask(map_b));
    vlm_iter_map #(.NREG(NREG), .BANK(BANK), .MAXLEN(MAXLEN)) u_map_d (
        .base(dst_idx), .is_double(is_double), .linear(1'b0), .iter_mask(map_d));

    vlm_iter_gate #(.MAXLEN(MAXLEN), .RF_SP(RF_SP), .RF_DP(RF_DP)) u_gate (
        .len_m1(len_m1), .kind(kind), .is_double(is_double), .is_mac(is_mac),
        .is_scalar(is_scalar), .runfast(runfast),
        .en_dst(en_dst), .en_src_a(en_a), .en_src_b(en_b), .en_src_d(en_d));

    vlm_mask_fold #(.NREG(NREG), .MAXLEN(MAXLEN)) u_fold_a (
        .iter_mask(map_a), .en(en_a), .mask(fold_a));
    vlm_mask_fold #(.NREG(NREG), .MAXLEN(MAXLEN)) u_fold_b (
        .iter_mask(map_b), .en(en_b), .mask(fold_b));
    vlm_mask_fold #(.NREG(NREG), .MAXLEN(MAXLEN)) u_fold_dsrc (
        .iter_mask(map_d), .en(en_d), .mask(fold_d_src));
    vlm_mask_fold #(.NREG(NREG), .MAXLEN(MAXLEN)) u_fold_dst (
        .iter_mask(map_d), .en(en_dst), .mask(fold_dst));

    // Combine operand contributions into the source mask.
    always_comb begin
        src_next = fold_a | fold_b | fold_d_src;
    end

    // Output register; masks are cleared when no descriptor is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            src_mask  <= '0;
            dst_mask  <= '0;
        end else begin
            out_valid <= in_valid;
            src_mask  <= in_valid ? src_next : '0;
            dst_mask  <= in_valid ? fold_dst : '0;
        end
    end

    // R1: one-cycle latency of the valid flag.
    assert_valid_lag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R2: idle outputs carry no locks.
    assert_idle_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (src_mask == '0 && dst_mask == '0));

    // R5: a scalar arithmetic operation writes one register.
    assert_scalar_dst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid && !is_store && is_scalar))
        |-> ($countones(dst_mask) == ($past(is_double) ? 2 : 1)));

    // R7: accumulator destinations are source-locked in full-compliance mode.
    assert_mac_dst_in_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid && !is_store && is_mac && !runfast))
        |-> ((dst_mask & ~src_mask) == '0));

    // R8: fast-mode single-precision vectors of four or fewer lock no sources.
    assert_rf_sp_short_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid && !is_store && !is_double && runfast
                               && (len_m1 < LW'(RF_SP))))
        |-> (src_mask == '0));

    // R9: fast-mode double-precision vectors of two or fewer lock no sources.
    assert_rf_dp_short_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid && !is_store && is_double && runfast
                               && (len_m1 < LW'(RF_DP))))
        |-> (src_mask == '0));

    // R10: stores never produce destination locks.
    assert_store_no_dst_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid && is_store)) |-> (dst_mask == '0));

    // R11: a multiple store locks exactly its run of registers.
    assert_multi_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid && is_store && is_multi && !is_double))
        |-> ($countones(src_mask) == 32'($past(len_m1)) + 1));
endmodule

// File: tb/vec_lock_mask_gen_bench.sv
// Scoreboard bench: a driver task queues expected masks, a monitor pops and
// compares them one edge later.
module vec_lock_mask_gen_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [31:0] src;
        logic [31:0] dst;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  src_a_idx = '0, src_b_idx = '0, dst_idx = '0;
    logic [2:0]  len_m1 = '0;
    logic        is_double = 0, is_mac = 0, is_scalar = 0;
    logic        is_store = 0, is_multi = 0, runfast = 0;
    logic        out_valid;
    logic [31:0] src_mask, dst_mask;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   mon_on   = 0;
    bit   done     = 0;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_lock_mask_gen u_vec_lock_mask_gen (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .src_a_idx(src_a_idx), .src_b_idx(src_b_idx), .dst_idx(dst_idx),
        .len_m1(len_m1), .is_double(is_double), .is_mac(is_mac),
        .is_scalar(is_scalar), .is_store(is_store), .is_multi(is_multi),
        .runfast(runfast), .out_valid(out_valid),
        .src_mask(src_mask), .dst_mask(dst_mask));

    // Slot bits for register number r (single slot or double pair).
    function automatic logic [31:0] reg_bits(input int r, input bit dbl);
        if (dbl) return (32'h3 << (2*r));
        return (32'h1 << r);
    endfunction

    // Register number of iteration i, banked (R3, R4) or linear (R11).
    function automatic int iter_reg(input int base, input int i, input bit dbl, input bit lin);
        int d;
        if (dbl) begin
            d = base % 16;
            if (lin) return (d + i) % 16;
            return (d / 4) * 4 + ((d + i) % 4);
        end
        if (lin) return (base + i) % 32;
        return (base / 8) * 8 + ((base + i) % 8);
    endfunction

    // Behavioural model of the expected masks from the requirements.
    function automatic exp_t model(input int a, input int b, input int dd, input int lm1,
                                   input bit dbl, input bit mac, input bit scl,
                                   input bit st, input bit mul, input bit rf);
        exp_t e;
        int   n;
        int   thr;
        e.src = '0;
        e.dst = '0;
        thr   = dbl ? 2 : 4;
        if (st && mul) begin
            for (int i = 0; i <= lm1; i++) e.src |= reg_bits(iter_reg(a, i, dbl, 1), dbl);
            e.tag = "R11";
        end else if (st) begin
            if (!rf) e.src = reg_bits(iter_reg(a, 0, dbl, 0), dbl);
            e.tag = "R10";
        end else begin
            n = (scl || lm1 == 0) ? 1 : lm1 + 1;
            for (int i = 0; i < n; i++) begin
                e.dst |= reg_bits(iter_reg(dd, i, dbl, 0), dbl);
                if (!rf || i >= thr) begin
                    e.src |= reg_bits(iter_reg(a, i, dbl, 0), dbl);
                    e.src |= reg_bits(iter_reg(b, i, dbl, 0), dbl);
                    if (mac) e.src |= reg_bits(iter_reg(dd, i, dbl, 0), dbl);
                end
            end
            if (rf && dbl)     e.tag = "R9";
            else if (rf)       e.tag = "R8";
            else if (mac)      e.tag = "R7";
            else if (n == 1)   e.tag = "R5";
            else if (dbl)      e.tag = "R4";
            else               e.tag = "R6/R3";
        end
        return e;
    endfunction

    // Driver: apply one descriptor on a falling edge and queue its expectation.
    task automatic drive(input int a, input int b, input int dd, input int lm1,
                         input bit dbl, input bit mac, input bit scl,
                         input bit st, input bit mul, input bit rf);
        @(negedge clk);
        in_valid  = 1'b1;
        src_a_idx = 5'(a); src_b_idx = 5'(b); dst_idx = 5'(dd);
        len_m1    = 3'(lm1);
        is_double = dbl; is_mac = mac; is_scalar = scl;
        is_store  = st;  is_multi = mul; runfast = rf;
        exp_q.push_back(model(a, b, dd, lm1, dbl, mac, scl, st, mul, rf));
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Monitor: check valid timing (R1), idle clearing (R2) and mask values.
    initial begin
        logic v_edge;
        exp_t e;
        forever begin
            @(posedge clk);
            v_edge = in_valid;
            #2;
            if (mon_on) begin
                n_checks++;
                if (out_valid !== v_edge) begin
                    n_fail++;
                    $display("FAIL R1: out_valid act %b exp %b", out_valid, v_edge);
                end
                if (out_valid === 1'b1) begin
                    n_checks++;
                    if (exp_q.size() == 0) begin
                        n_fail++;
                        $display("FAIL R1: result with empty queue act src %h dst %h exp none",
                                 src_mask, dst_mask);
                    end else begin
                        e = exp_q.pop_front();
                        if (src_mask !== e.src || dst_mask !== e.dst) begin
                            n_fail++;
                            $display("FAIL %s: src act %h exp %h, dst act %h exp %h",
                                     e.tag, src_mask, e.src, dst_mask, e.dst);
                        end
                    end
                end else begin
                    n_checks++;
                    if (src_mask !== '0 || dst_mask !== '0) begin
                        n_fail++;
                        $display("FAIL R2: idle src act %h dst act %h exp 0 0", src_mask, dst_mask);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run act hung exp finished");
            report();
        end
    end

    // Stimulus.
    initial begin
        int n;
        // R2: reset state, with a descriptor present during reset.
        in_valid = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        n_checks++;
        if (out_valid !== 1'b0 || src_mask !== '0 || dst_mask !== '0) begin
            n_fail++;
            $display("FAIL R2: reset act v%b %h %h exp v0 0 0", out_valid, src_mask, dst_mask);
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b1;
        mon_on   = 1;
        // Directed corners: bank wrap single (R3), double wrap (R4),
        // linear wrap of multiple store (R11), fast-mode thresholds (R8, R9).
        drive(7, 15, 31, 1, 0, 0, 0, 0, 0, 0);
        drive(15, 2, 15, 3, 1, 0, 0, 0, 0, 0);
        drive(30, 0, 0, 3, 0, 0, 0, 1, 1, 1);
        drive(15, 0, 0, 2, 1, 0, 1, 1, 1, 0);
        drive(3, 9, 17, 4, 0, 1, 0, 0, 0, 1);
        drive(3, 9, 17, 2, 1, 1, 0, 0, 0, 1);
        drive(6, 0, 0, 5, 0, 0, 0, 1, 0, 0);
        idle();
        // Sweep every length against every flag combination.
        n = 0;
        for (int lm = 0; lm < 8; lm++) begin
            for (int f = 0; f < 64; f++) begin
                drive((n*7+3)%32, (n*11+5)%32, (n*13+1)%32, lm,
                      f[0], f[1], f[2], f[3], f[4], f[5]);
                n++;
                if (n % 5 == 0) idle();
            end
        end
        idle();
        idle();
        @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R1: leftover results act %0d exp 0", exp_q.size());
        end
        done = 1;
        report();
    end
endmodule